// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

The block is a small direct-mapped data cache placed between a byte-wide processor port and a backing memory that moves whole lines. Each request carries a 12-bit byte address, which is cut into a 4-bit tag (bits 11:8), a 4-bit line index (bits 7:4) and a 4-bit byte offset (bits 3:0). The indexed line's valid flag, stored tag and dirty flag decide whether the access hits.

Hits are served from the 16-byte line store with no memory traffic. A miss on a read or a write runs a fixed sequence. If the old line is valid and dirty, it is first copied out to memory. The new line is then fetched in full. Finally the byte access is replayed against the freshly filled line. Writes allocate on a miss and mark the line dirty, so a modified line reaches memory only when a conflicting address evicts it.

Top module: `dmc_cache`

## Requirements
- R1: After reset, `cpu_ready` is 1, `cpu_resp` is 0 and `mem_req` is 0. Every line is invalid, so the first access to any address fetches its line from memory.
- R2: The line is selected by address bits 7:4. A fill requests block address `cpu_addr[11:4]`, which is the request address with its four offset bits dropped.
- R3: A read hit (line valid and tag equal to bits 11:8) raises `cpu_resp` in the second cycle after acceptance. It returns the addressed byte and raises no `mem_req`.
- R4: A read miss fetches the whole 16-byte block and then returns the requested byte. `mem_rdata` byte k (bits 8k+7:8k) is the byte at offset k.
- R5: A write hit changes only the addressed byte, sets the line dirty and makes no memory transfer.
- R6: A write miss fills the line from memory first, then merges the written byte and sets the line dirty.
- R7: On a miss whose victim line is valid and dirty, exactly one write transfer (`mem_we`=1) happens before the fill. It uses block address {old tag, index} and carries the line's current contents, in the byte order of R4.
- R8: A clean or invalid victim is replaced without any memory write. A fill leaves the line valid and clean.
- R9: Data that was written back is returned unchanged when the block is later fetched again.
- R10: `cpu_ready` is 1 only when idle. It drops for every cycle from acceptance until the single-cycle `cpu_resp` pulse, and no `mem_req` is raised while ready.
- R11: `mem_req`, `mem_we` and `mem_addr` stay stable until a one-cycle `mem_done` ends the transfer. Fill data is taken in the `mem_done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Cache idle, request accepted this cycle if valid |
| cpu_we | input | 1 | 1 = byte write, 0 = byte read |
| cpu_addr | input | 12 | Byte address: tag 11:8, index 7:4, offset 3:0 |
| cpu_wdata | input | 8 | Byte to write |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte (written byte for writes), valid with cpu_resp |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | 8 | Block address (tag, index) |
| mem_wdata | output | 128 | Line contents for write-back |
| mem_rdata | input | 128 | Block contents for fill |
| mem_done | input | 1 | One-cycle transfer completion |

## Verification
The bench builds the default geometry of 4 tag bits, 4 index bits and 4 offset bits, against a memory model with a three-cycle response. At this size the whole 4096-byte address space is small enough to read exhaustively, before and after a strided write sweep. Every line therefore sees cold misses, clean replacements, dirty evictions and refetches of written-back data. Expected bytes, hit or miss, write-back addresses and write-back contents all come from a flat reference memory and a tag model of the cache kept in the bench.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int TAG_W      = 4;
    localparam int IDX_W      = 4;
    localparam int OFF_W      = 4;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = TAG_W + IDX_W + OFF_W;
    localparam int BLK_W      = TAG_W + IDX_W;
    localparam int LINES      = 1 << IDX_W;
    localparam int LINE_BYTES = 1 << OFF_W;
    localparam int LINE_W     = LINE_BYTES * BYTE_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL
    } state_e;

    typedef struct packed {
        logic  we;
        tag_t  tag;
        idx_t  idx;
        off_t  off;
        byte_t wdata;
    } req_t;

    function automatic req_t make_req(logic we, addr_t a, byte_t d);
        req_t r;
        r.we    = we;
        r.tag   = a[ADDR_W-1 -: TAG_W];
        r.idx   = a[OFF_W +: IDX_W];
        r.off   = a[OFF_W-1:0];
        r.wdata = d;
        return r;
    endfunction

    function automatic blk_t blk_of(tag_t t, idx_t i);
        return {t, i};
    endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t idx,
    input  logic fill_en,
    input  tag_t fill_tag,
    input  logic dirty_set,
    output logic rd_valid,
    output tag_t rd_tag,
    output logic rd_dirty
);
    logic valid_q [LINES];
    logic dirty_q [LINES];
    tag_t tag_q   [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= 1'b0;
                dirty_q[i] <= 1'b0;
                tag_q[i]   <= '0;
            end
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
            tag_q[idx]   <= fill_tag;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_dirty = dirty_q[idx];
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
(
    input  logic  clk,
    input  idx_t  idx,
    input  off_t  off,
    input  logic  fill_en,
    input  line_t fill_line,
    input  logic  byte_we,
    input  byte_t wbyte,
    output byte_t rd_byte,
    output line_t rd_line
);
    byte_t mem_q [LINES][LINE_BYTES];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            for (int b = 0; b < LINE_BYTES; b++)
                mem_q[idx][b] <= fill_line[b*BYTE_W +: BYTE_W];
        end else if (byte_we) begin
            mem_q[idx][off] <= wbyte;
        end
    end

    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
        assign rd_line[g*BYTE_W +: BYTE_W] = mem_q[idx][g];
    end

    assign rd_byte = mem_q[idx][off];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cpu_valid,
    input  logic  cpu_we,
    input  addr_t cpu_addr,
    input  byte_t cpu_wdata,
    output logic  cpu_ready,
    output logic  cpu_resp,
    output byte_t cpu_rdata,
    output idx_t  lk_idx,
    output off_t  lk_off,
    input  logic  lk_valid,
    input  tag_t  lk_tag,
    input  logic  lk_dirty,
    input  byte_t lk_byte,
    output logic  fill_en,
    output tag_t  fill_tag,
    output logic  hit_write,
    output byte_t wbyte,
    output logic  mem_req,
    output logic  mem_we,
    output blk_t  mem_addr,
    input  logic  mem_done
);
    state_e st_q;
    req_t   req_q;
    logic   hit;

    assign hit = lk_valid && (lk_tag == req_q.tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            req_q     <= '0;
            cpu_resp  <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            cpu_resp <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cpu_valid) begin
                        req_q <= make_req(cpu_we, cpu_addr, cpu_wdata);
                        st_q  <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        cpu_resp  <= 1'b1;
                        cpu_rdata <= req_q.we ? req_q.wdata : lk_byte;
                        st_q      <= ST_IDLE;
                    end else if (lk_valid && lk_dirty) begin
                        st_q <= ST_WBACK;
                    end else begin
                        st_q <= ST_FILL;
                    end
                end
                ST_WBACK: if (mem_done) st_q <= ST_FILL;
                ST_FILL:  if (mem_done) st_q <= ST_LOOKUP;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cpu_ready = (st_q == ST_IDLE);
        mem_req   = (st_q == ST_WBACK) || (st_q == ST_FILL);
        mem_we    = (st_q == ST_WBACK);
        mem_addr  = (st_q == ST_WBACK) ? blk_of(lk_tag, req_q.idx)
                                       : blk_of(req_q.tag, req_q.idx);
        fill_en   = (st_q == ST_FILL) && mem_done;
        hit_write = (st_q == ST_LOOKUP) && hit && req_q.we;
    end

    assign lk_idx   = req_q.idx;
    assign lk_off   = req_q.off;
    assign fill_tag = req_q.tag;
    assign wbyte    = req_q.wdata;
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic              cpu_resp,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [BLK_W-1:0]  mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_done
);
    idx_t  lk_idx;
    off_t  lk_off;
    logic  lk_valid;
    tag_t  lk_tag;
    logic  lk_dirty;
    byte_t lk_byte;
    logic  fill_en;
    tag_t  fill_tag;
    logic  hit_write;
    byte_t wbyte;

    dmc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_valid (cpu_valid),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_resp  (cpu_resp),
        .cpu_rdata (cpu_rdata),
        .lk_idx    (lk_idx),
        .lk_off    (lk_off),
        .lk_valid  (lk_valid),
        .lk_tag    (lk_tag),
        .lk_dirty  (lk_dirty),
        .lk_byte   (lk_byte),
        .fill_en   (fill_en),
        .fill_tag  (fill_tag),
        .hit_write (hit_write),
        .wbyte     (wbyte),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_done  (mem_done)
    );

    dmc_tag_store u_tags (
        .clk       (clk),
        .rst       (rst),
        .idx       (lk_idx),
        .fill_en   (fill_en),
        .fill_tag  (fill_tag),
        .dirty_set (hit_write),
        .rd_valid  (lk_valid),
        .rd_tag    (lk_tag),
        .rd_dirty  (lk_dirty)
    );

    dmc_data_store u_data (
        .clk       (clk),
        .idx       (lk_idx),
        .off       (lk_off),
        .fill_en   (fill_en),
        .fill_line (mem_rdata),
        .byte_we   (hit_write),
        .wbyte     (wbyte),
        .rd_byte   (lk_byte),
        .rd_line   (mem_wdata)
    );
endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk
    import dmc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cpu_valid,
    input logic             cpu_ready,
    input logic             cpu_resp,
    input logic             mem_req,
    input logic             mem_we,
    input logic [BLK_W-1:0] mem_addr,
    input logic             mem_done
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cpu_ready && !mem_req && !cpu_resp)); // R1

    AST_READY_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !mem_req); // R10

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_ready) |=> !cpu_ready); // R10

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_resp |=> !cpu_resp); // R10

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R11

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_done) |=> (mem_req && !mem_we)); // R7

    AST_FILL_REPLAY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_done) |=> (!cpu_resp && !cpu_ready && !mem_req)); // R4
endmodule

bind dmc_cache dmc_cache_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_valid (cpu_valid),
    .cpu_ready (cpu_ready),
    .cpu_resp  (cpu_resp),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_done  (mem_done)
);

// File: tb/dmc_cache_bench.sv
module dmc_cache_bench;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_valid = 1'b0;
    logic         cpu_ready;
    logic         cpu_we = 1'b0;
    logic [11:0]  cpu_addr = '0;
    logic [7:0]   cpu_wdata = '0;
    logic         cpu_resp;
    logic [7:0]   cpu_rdata;
    logic         mem_req;
    logic         mem_we;
    logic [7:0]   mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] bmem [4096];
    logic [7:0] rmem [4096];
    logic       bv   [16];
    logic [3:0] btag [16];
    logic       bdty [16];

    int         n_wb, n_fill, cnt;
    logic       order_bad;
    logic [7:0] wb_addr, fill_addr;

    always #5 clk = ~clk;

    dmc_cache u_dmc_cache (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    task automatic chk(input logic ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // backing memory model
    always @(posedge clk) begin
        if (rst || mem_done) begin
            mem_done <= 1'b0;
            cnt <= 0;
        end else if (mem_req) begin
            if (cnt == LAT-1) begin
                for (int b = 0; b < 16; b++) begin
                    if (mem_we) bmem[{mem_addr, 4'(b)}] <= mem_wdata[b*8 +: 8];
                    else        mem_rdata[b*8 +: 8] <= bmem[{mem_addr, 4'(b)}];
                end
                mem_done <= 1'b1;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    // transfer monitor
    always @(negedge clk) begin
        if (!rst && mem_req && mem_done) begin
            if (mem_we) begin
                logic [127:0] exp_line;
                for (int b = 0; b < 16; b++) exp_line[b*8 +: 8] = rmem[{mem_addr, 4'(b)}];
                n_wb++;
                wb_addr = mem_addr;
                if (n_fill != 0) order_bad = 1'b1;
                chk(mem_wdata == exp_line, "R7 write-back contents",
                    int'(mem_wdata[31:0]), int'(exp_line[31:0]));
            end else begin
                n_fill++;
                fill_addr = mem_addr;
            end
        end
    end

    task automatic access(input logic we, input logic [11:0] a, input logic [7:0] d);
        logic [3:0] ix = a[7:4];
        logic [3:0] tg = a[11:8];
        logic hit_e = bv[ix] && (btag[ix] == tg);
        logic wb_e  = !hit_e && bv[ix] && bdty[ix];
        logic [7:0] wba_e = {btag[ix], ix};
        logic ready_ok = 1'b1;
        int waited = 0;
        n_wb = 0; n_fill = 0; order_bad = 1'b0;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_valid = 1'b0;
        while (!cpu_resp && waited < 200) begin
            if (cpu_ready) ready_ok = 1'b0;
            @(negedge clk);
            waited++;
        end
        chk(cpu_resp && ready_ok, "R10 ready low until response", int'(ready_ok), 1);
        if (hit_e) begin
            chk(waited == 1 && n_wb == 0 && n_fill == 0,
                we ? "R5 write hit without memory" : "R3 read hit latency/no memory",
                waited, 1);
        end else begin
            chk(n_fill == 1 && fill_addr == a[11:4], "R2 fill block address",
                int'(fill_addr), int'(a[11:4]));
            if (we) chk(n_fill == 1, "R6 write miss allocates", n_fill, 1);
            if (wb_e) begin
                chk(n_wb == 1 && wb_addr == wba_e && !order_bad,
                    "R7 dirty victim written first", int'(wb_addr), int'(wba_e));
            end else begin
                chk(n_wb == 0, "R8 clean victim no write", n_wb, 0);
            end
        end
        if (!we) begin
            chk(cpu_rdata == rmem[a], hit_e ? "R3 read hit data" : "R4 read miss data",
                int'(cpu_rdata), int'(rmem[a]));
            if (rmem[a] != a[7:0])
                chk(cpu_rdata == rmem[a], "R9 written data returned",
                    int'(cpu_rdata), int'(rmem[a]));
        end else begin
            rmem[a] = d;
        end
        bdty[ix] = hit_e ? (bdty[ix] | we) : we;
        bv[ix]   = 1'b1;
        btag[ix] = tg;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            bmem[i] = 8'(i);
            rmem[i] = 8'(i);
        end
        for (int i = 0; i < 16; i++) begin
            bv[i] = 1'b0; btag[i] = '0; bdty[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(cpu_ready && !cpu_resp && !mem_req, "R1 reset state", int'(cpu_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready && !cpu_resp && !mem_req, "R1 idle after reset", int'(mem_req), 0);

        // directed sequence
        access(1'b0, 12'h005, 8'h00);
        chk(n_fill == 1, "R1 first access after reset misses", n_fill, 1);
        access(1'b0, 12'h006, 8'h00);
        access(1'b0, 12'h14C, 8'h00);
        access(1'b1, 12'h14C, 8'h99);
        access(1'b0, 12'h14C, 8'h00);
        access(1'b0, 12'h14D, 8'h00);
        access(1'b0, 12'h348, 8'h00);
        access(1'b0, 12'h14C, 8'h00);
        chk(cpu_rdata == 8'h99, "R9 refetched byte", int'(cpu_rdata), 'h99);
        access(1'b1, 12'h63B, 8'h07);
        access(1'b0, 12'h03F, 8'h00);
        access(1'b0, 12'h63B, 8'h00);
        chk(cpu_rdata == 8'h07, "R9 write-miss byte refetched", int'(cpu_rdata), 7);

        // sweep 1: read every address
        for (int a = 0; a < 4096; a++) access(1'b0, 12'(a), 8'h00);
        // sweep 2: strided writes
        for (int a = 0; a < 4096; a += 5) access(1'b1, 12'(a), 8'(a * 3 + 1));
        // sweep 3: read every address again
        for (int a = 0; a < 4096; a++) access(1'b0, 12'(a), 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule